// File: doc/BRIEF.md
# Unit-Stride Vector Load Sequencer

This block turns a single vector load into a run of element loads. On a start pulse it captures a base address, a signed immediate offset, the memory width of one element, a vector length and the destination element width, together with the first destination register. It then walks the elements in order. For each element it presents one read request on a valid/ready memory port, waits for the returned data, and writes that data into a vector register file made of 64-bit registers. Elements are packed back to back at the destination element width, and a group of elements can spill over into the registers that follow the first one.

The memory width and the destination width are separate settings. The element address steps by the memory width. The packing position comes from the destination width. The source and destination element counters always move together. Any sign or zero extension, saturation or byte swapping is done upstream, so the block takes the low destination-width bits of each response as they arrive. A length of one with both widths at 64 bits is an ordinary scalar doubleword load.

Top module: `vld_seq`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `mem_req_valid`, `rf_we`, `done` and `busy` are all 0.
- R2: The address of element i is `base_addr + imm_offs + i * 2^op_size`, wrapping at the address width. Width codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. `mem_req_size` carries the captured `op_size` code.
- R3: Only one read is outstanding at a time. A request stays valid with a stable address until `mem_req_ready` is seen. No new request is raised until the previous element has been written. A request and a register write never share a cycle.
- R4: Exactly `vec_len` requests and `vec_len` writes are made, for elements 0 to `vec_len-1` in order. `done` is high for exactly one cycle, in the cycle after the last write, and `busy` is low in the cycle after that.
- R5: A `vec_len` of 0 makes no memory request and no write. `done` pulses in the cycle after the start.
- R6: With destination width d bits (code `dst_size`, same encoding as R2), element j is written to register `(rf_base + (j*d)/64) mod 2^REG_W`.
- R7: The write enables exactly d/8 byte lanes, starting at lane ((j*d) mod 64)/8. Bit k of `rf_be` covers data bits 8k+7..8k.
- R8: `rf_wdata` holds the low d bits of the response shifted left by (j*d) mod 64. All bits outside the enabled lanes are 0.
- R9: A start pulse while the block is busy is ignored.
- R10: With `vec_len`=1 and both width codes 3, a single write to `rf_base` has all eight lanes enabled and carries the response unchanged.
- R11: All operands are captured at the accepted start. Input changes after that have no effect on addresses or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when idle |
| base_addr | input | ADDR_W | Base address |
| imm_offs | input | ADDR_W | Immediate offset (two's complement) |
| op_size | input | 2 | Memory width code of one element |
| dst_size | input | 2 | Destination element width code |
| vec_len | input | VL_W | Number of elements |
| rf_base | input | REG_W | First destination register |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Read address |
| mem_req_size | output | 2 | Read width code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-aligned |
| rf_we | output | 1 | Register write strobe |
| rf_idx | output | REG_W | Register number |
| rf_be | output | 8 | Byte-lane enables |
| rf_wdata | output | 64 | Lane-aligned write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with ADDR_W=32, VL_W=4 and REG_W=5. With these values it can sweep every pair of memory and destination width codes against every vector length from 0 to 15. That covers every packing position inside a register and groups that cross several registers. Choosing some first registers near 31 makes the register number wrap. Alternating positive and negative offsets tests address wrap. Varying the grant stall and the response latency exercises the single-outstanding rule, and a start pulse injected while busy, together with scrambled inputs after each start, tests that the captured operands are held.

// File: rtl/vld_pkg.sv
// Package vld_pkg
// Shared state encoding and width-code helpers for the unit-stride load sequencer.
// Assumes 64-bit vector registers split into eight byte lanes.
package vld_pkg;
    localparam int RF_BITS  = 64;
    localparam int RF_LANES = RF_BITS / 8;

    typedef logic [1:0] wcode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_WRITE,
        ST_FIN
    } vld_state_e;

    // Byte count of a width code (1, 2, 4 or 8).
    function automatic logic [3:0] code_bytes(wcode_t c);
        return 4'd1 << c;
    endfunction
endpackage

// File: rtl/vld_ctrl.sv
// Module vld_ctrl
// Sequencing FSM: accepts a start when idle, then for each element raises a
// request, waits for its response and issues one write. It keeps the source and
// destination element counters. Assumes one response per granted request.
module vld_ctrl
    import vld_pkg::*;
#(
    parameter int VL_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VL_W-1:0] vl_in,
    input  logic            req_ready,
    input  logic            rsp_valid,
    output logic            accept,
    output logic            rsp_take,
    output logic            req_valid,
    output logic            wr_en,
    output logic            busy,
    output logic            done,
    output logic [VL_W-1:0] src_idx,
    output logic [VL_W-1:0] dst_idx
);
    vld_state_e      state;
    logic [VL_W-1:0] vl_q;
    logic [VL_W-1:0] src_nxt;
    logic [VL_W-1:0] dst_nxt;

    // Decode the handshake strobes from the current state.
    always_comb begin
        accept    = (state == ST_IDLE) && start;
        rsp_take  = (state == ST_WAIT) && rsp_valid;
        req_valid = (state == ST_REQ);
        wr_en     = (state == ST_WRITE);
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        src_nxt   = src_idx + 1'b1;
        dst_nxt   = dst_idx + 1'b1;
    end

    // State and element-counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            vl_q    <= '0;
            src_idx <= '0;
            dst_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        vl_q    <= vl_in;
                        src_idx <= '0;
                        dst_idx <= '0;
                        state   <= (vl_in == '0) ? ST_FIN : ST_REQ;
                    end
                end
                ST_REQ:   if (req_ready) state <= ST_WAIT;
                ST_WAIT:  if (rsp_valid) state <= ST_WRITE;
                ST_WRITE: begin
                    src_idx <= src_nxt;
                    dst_idx <= dst_nxt;
                    state   <= ((src_nxt < vl_q) && (dst_nxt < vl_q)) ? ST_REQ : ST_FIN;
                end
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // R4: source and destination counters never drift apart.
    p_lockstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        src_idx == dst_idx);

    // R4: completion is a single-cycle pulse followed by idle.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R5: an empty vector completes in the next cycle with no request.
    p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (vl_in == '0) |=> done && !req_valid);
endmodule

// File: rtl/vld_addr_gen.sv
// Module vld_addr_gen
// Combinational address of the current element:
// base + immediate + index * element bytes.
// Assumes the address wraps at ADDR_W bits and that VL_W < ADDR_W.
module vld_addr_gen
    import vld_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] imm,
    input  wcode_t            op_code,
    input  logic [VL_W-1:0]   idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - VL_W;

    logic [ADDR_W-1:0] step;

    // Scale the element index by the element size and add both offsets.
    always_comb begin
        step = {{PAD_W{1'b0}}, idx} << op_code;
        addr = base + imm + step;
    end
endmodule

// File: rtl/vld_place.sv
// Module vld_place
// Works out where element j lands in the packed register group: register number,
// byte-lane enables and lane-aligned data. Assumes the element value is
// right-aligned in elem and that the destination width is at most 64 bits.
module vld_place
    import vld_pkg::*;
#(
    parameter int VL_W  = 4,
    parameter int REG_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    rt,
    input  wcode_t              dst_code,
    input  logic [VL_W-1:0]     j,
    input  logic [RF_BITS-1:0]  elem,
    output logic [REG_W-1:0]    rf_idx,
    output logic [RF_LANES-1:0] rf_be,
    output logic [RF_BITS-1:0]  rf_wdata
);
    localparam int POS_W = VL_W + 6;

    logic [POS_W-1:0]    bit_pos;
    logic [5:0]          bit_off;
    logic [RF_BITS-1:0]  val_mask;
    logic [RF_LANES-1:0] be_base;
    logic [RF_BITS-1:0]  lane_bits;

    // Bit position of the element within the register group.
    always_comb begin
        bit_pos = {6'b0, j} << (3'd3 + {1'b0, dst_code});
        bit_off = bit_pos[5:0];
        rf_idx  = rt + REG_W'(bit_pos >> 6);
    end

    // Lane pattern and value mask for the destination width.
    always_comb begin
        case (dst_code)
            2'd0:    begin be_base = 8'h01; val_mask = 64'h0000_0000_0000_00FF; end
            2'd1:    begin be_base = 8'h03; val_mask = 64'h0000_0000_0000_FFFF; end
            2'd2:    begin be_base = 8'h0F; val_mask = 64'h0000_0000_FFFF_FFFF; end
            default: begin be_base = 8'hFF; val_mask = 64'hFFFF_FFFF_FFFF_FFFF; end
        endcase
        rf_be    = be_base << bit_off[5:3];
        rf_wdata = (elem & val_mask) << bit_off;
    end

    // Expand the byte enables to a bit mask, used by the lane check.
    for (genvar g = 0; g < RF_LANES; g++) begin : g_lane
        assign lane_bits[g*8 +: 8] = {8{rf_be[g]}};
    end

    // R7: the number of enabled lanes matches the destination width.
    p_be_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(rf_be) == int'(code_bytes(dst_code))));

    // R8: no data bit is set outside the enabled lanes.
    p_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((rf_wdata & ~lane_bits) == '0));
endmodule

// File: rtl/vld_seq.sv
// Module vld_seq (top)
// Unit-stride vector load sequencer. It captures the operands on start, then
// issues one memory read per element and one packed register write per
// response. Assumes the memory side returns exactly one response per granted
// request and that data formatting is done upstream.
module vld_seq
    import vld_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 4,
    parameter int REG_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [ADDR_W-1:0]   imm_offs,
    input  logic [1:0]          op_size,
    input  logic [1:0]          dst_size,
    input  logic [VL_W-1:0]     vec_len,
    input  logic [REG_W-1:0]    rf_base,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [1:0]          mem_req_size,
    input  logic                mem_rsp_valid,
    input  logic [63:0]         mem_rsp_data,
    output logic                rf_we,
    output logic [REG_W-1:0]    rf_idx,
    output logic [7:0]          rf_be,
    output logic [63:0]         rf_wdata,
    output logic                busy,
    output logic                done
);
    logic              accept;
    logic              rsp_take;
    logic [VL_W-1:0]   src_idx;
    logic [VL_W-1:0]   dst_idx;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] imm_q;
    wcode_t            op_q;
    wcode_t            dc_q;
    logic [REG_W-1:0]  rt_q;
    logic [63:0]       data_q;

    // Capture the operands when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            imm_q  <= '0;
            op_q   <= '0;
            dc_q   <= '0;
            rt_q   <= '0;
        end else if (accept) begin
            base_q <= base_addr;
            imm_q  <= imm_offs;
            op_q   <= op_size;
            dc_q   <= dst_size;
            rt_q   <= rf_base;
        end
    end

    // Hold the returned element until it is written.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else if (rsp_take) data_q <= mem_rsp_data;
    end

    vld_ctrl #(.VL_W(VL_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vl_in     (vec_len),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .accept    (accept),
        .rsp_take  (rsp_take),
        .req_valid (mem_req_valid),
        .wr_en     (rf_we),
        .busy      (busy),
        .done      (done),
        .src_idx   (src_idx),
        .dst_idx   (dst_idx)
    );

    vld_addr_gen #(.ADDR_W(ADDR_W), .VL_W(VL_W)) addr_i (
        .base    (base_q),
        .imm     (imm_q),
        .op_code (op_q),
        .idx     (src_idx),
        .addr    (mem_req_addr)
    );

    vld_place #(.VL_W(VL_W), .REG_W(REG_W)) place_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rf_we),
        .rt       (rt_q),
        .dst_code (dc_q),
        .j        (dst_idx),
        .elem     (data_q),
        .rf_idx   (rf_idx),
        .rf_be    (rf_be),
        .rf_wdata (rf_wdata)
    );

    assign mem_req_size = op_q;

    // R3: a stalled request holds its address until granted.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R3: requesting and writing are mutually exclusive.
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && rf_we));

    // R9: a start while busy does not restart the sequence.
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy);
endmodule

// File: tb/vld_seq_tb_top.sv
// Bench for vld_seq: sweeps all width-code pairs and vector lengths 0..15,
// with expected values computed arithmetically.
module vld_seq_tb_top;
    localparam int ADDR_W = 32;
    localparam int VL_W   = 4;
    localparam int REG_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [ADDR_W-1:0] imm_offs = '0;
    logic [1:0]        op_size = '0;
    logic [1:0]        dst_size = '0;
    logic [VL_W-1:0]   vec_len = '0;
    logic [REG_W-1:0]  rf_base = '0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [1:0]        mem_req_size;
    logic              mem_rsp_valid = 1'b0;
    logic [63:0]       mem_rsp_data = '0;
    logic              rf_we;
    logic [REG_W-1:0]  rf_idx;
    logic [7:0]        rf_be;
    logic [63:0]       rf_wdata;
    logic              busy;
    logic              done;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    vld_seq #(.ADDR_W(ADDR_W), .VL_W(VL_W), .REG_W(REG_W)) dut_i (.*);

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_val(logic [31:0] a);
        return {a ^ 32'h5A3C_96E1, a + 32'h1357_9BDF};
    endfunction

    task automatic run(int op, int dc, int vl, logic [31:0] base, logic [31:0] imm,
                       int rt, int salt);
        int          d;
        logic [31:0] exp_addr;
        logic [63:0] rd;
        logic [63:0] msk;
        int          pos;
        d = 8 << dc;
        @(negedge clk);
        base_addr = base; imm_offs = imm; op_size = 2'(op); dst_size = 2'(dc);
        vec_len = VL_W'(vl); rf_base = REG_W'(rt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: scramble all operands after the accepted start
        base_addr = ~base; imm_offs = 32'h0BAD_F00D; op_size = ~op_size;
        dst_size = ~dst_size; vec_len = ~vec_len; rf_base = ~rf_base;
        if (vl == 0) begin
            chk("R5", "done", 64'(done), 64'd1);
            chk("R5", "req_valid", 64'(mem_req_valid), 64'd0);
            @(negedge clk);
            chk("R4", "busy after done", 64'(busy), 64'd0);
            return;
        end
        for (int e = 0; e < vl; e++) begin
            exp_addr = base + imm + 32'(e << op);
            chk("R2", "req_valid", 64'(mem_req_valid), 64'd1);
            chk("R2", "addr", 64'(mem_req_addr), 64'(exp_addr)); // R11 too
            chk("R2", "size", 64'(mem_req_size), 64'(op));
            for (int s = 0; s < (e + salt) % 3; s++) begin
                @(negedge clk);
                chk("R3", "stalled valid", 64'(mem_req_valid), 64'd1);
                chk("R3", "stalled addr", 64'(mem_req_addr), 64'(exp_addr));
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk("R3", "no request while waiting", 64'(mem_req_valid), 64'd0);
            if (e == 0) begin
                // R9: spurious start while busy
                start = 1'b1; vec_len = 4'd1; base_addr = 32'hDEAD_0000;
                @(negedge clk);
                start = 1'b0;
                chk("R9", "busy", 64'(busy), 64'd1);
            end
            for (int w = 0; w < (e + op) % 2; w++) begin
                @(negedge clk);
                chk("R3", "no write before response", 64'(rf_we), 64'd0);
            end
            rd = mem_val(exp_addr);
            mem_rsp_valid = 1'b1; mem_rsp_data = rd;
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_data = '0;
            pos = e * d;
            msk = (d == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << d) - 64'd1);
            chk("R4", "we", 64'(rf_we), 64'd1);
            chk("R6", "idx", 64'(rf_idx), 64'((rt + pos / 64) % 32));
            chk("R7", "be", 64'(rf_be), 64'((((1 << (d / 8)) - 1) << ((pos % 64) / 8)) & 8'hFF));
            chk((vl == 1 && op == 3 && dc == 3) ? "R10" : "R8", "wdata",
                rf_wdata, (rd & msk) << (pos % 64));
            @(negedge clk);
            chk("R4", "we drop", 64'(rf_we), 64'd0);
            if (e == vl - 1) begin
                chk("R4", "done", 64'(done), 64'd1);
                chk("R4", "no extra request", 64'(mem_req_valid), 64'd0);
                @(negedge clk);
                chk("R4", "done pulse", 64'(done), 64'd0);
                chk("R4", "idle", 64'(busy), 64'd0);
            end else begin
                chk("R4", "no early done", 64'(done), 64'd0);
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1", "we", 64'(rf_we), 64'd0);
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "busy", 64'(busy), 64'd0);
        for (int op = 0; op < 4; op++)
            for (int dc = 0; dc < 4; dc++)
                for (int vl = 0; vl < 16; vl++)
                    run(op, dc, vl,
                        32'h1000_0000 + 32'(op * 4096 + dc * 256 + vl * 8),
                        (vl % 2 == 1) ? 32'hFFFF_FFF0 : 32'h0000_0040,
                        (vl * 7 + dc * 9 + 24) % 32, op + dc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule